// File: doc/BRIEF.md
# SPI Command and Register Decoder

This block is the slave side of a mode 0 SPI link. Each transaction is framed by chip select going low. The first eight bits clocked in are a command byte. The two top bits decide what it means. A prefix of `01` or `00` carries a 6-bit register address and selects a write or a read of a flat 64-byte register file. A prefix of `1x` must match one of six fixed stream opcodes. Three of these pull bytes from external read buffers and three push bytes to external write buffers. `0xFF` is an idle command, and every other `1x` value is treated as illegal.

The SPI pins are synchronised into the system clock and their edges are detected there, so all logic runs on one clock. The response byte for the next SPI byte is loaded at the falling SCLK edge that follows each completed byte. When chip select rises, a one-cycle end-of-frame strobe reports which command the frame carried. Hardware elsewhere on the chip reads the register file through a combinational local port.

Streams use a valid/ready handshake, with the following back-pressure rules. For a read stream, the block raises `rs_ready` for one cycle whenever it needs a byte. A transfer happens only if `rs_valid` is high in that cycle; otherwise `0x00` is sent. For a write stream, the block raises `ws_valid` for one cycle per received byte. The SPI master cannot be stalled, so a byte offered while `ws_ready` is low is dropped and never offered again.

Top module: `spi_cmd_regdec`

## Requirements
- R1: SPI mode 0. MOSI is sampled on the rising SCLK edge, MSB first. MISO changes only after a falling SCLK edge or the falling edge of chip select. Chip select low clears the bit counter, the first 8 bits form the command byte, and MISO is 0 during the command byte.
- R2: A command `01AAAAAA` writes each following complete byte into the register file, starting at address AAAAAA. The address increments after each byte and wraps from 63 to 0.
- R3: A command `00AAAAAA` returns register contents MSB first from the second SPI byte onward, starting at AAAAAA. The address auto-increments and wraps from 63 to 0.
- R4: Commands `0x81`, `0x83` and `0x87` are read streams with `rs_sel` equal to 0, 1 and 2. Each completed SPI byte, the command byte included, raises `rs_ready` for one cycle. The byte taken is sent as the next SPI byte, or `0x00` if `rs_valid` was low.
- R5: Commands `0x91`, `0x93` and `0x97` are write streams with `ws_sel` equal to 0, 1 and 2. Each following complete byte appears on `ws_data` with a one-cycle `ws_valid`, and is dropped if `ws_ready` is low in that cycle.
- R6: Command `0xFF` changes no register and produces no stream traffic. MISO stays 0 for the whole frame.
- R7: Any other command with a `1x` prefix is ignored like `0xFF`, and MISO returns `0x00` for the rest of the frame.
- R8: After chip select rises on a frame with a complete command byte, `eof_valid` pulses for exactly one cycle. `eof_cmd` then holds the command code: 1 register write, 2 register read, 3/4/5 read stream 0/1/2, 6/7/8 write stream 0/1/2, 9 idle (`0xFF`), 10 illegal. A frame with fewer than 8 bits produces no strobe.
- R9: An incomplete byte at the end of a frame is discarded and writes nothing.
- R10: After reset, all registers read 0, MISO is 0, and `eof_valid`, `ws_valid` and `rs_ready` are low.
- R11: `loc_data` shows the register addressed by `loc_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock (idle low) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from master |
| spi_miso | output | 1 | SPI data to master |
| rs_valid | input | 1 | Read-stream source has a byte |
| rs_data | input | 8 | Read-stream byte |
| rs_ready | output | 1 | Block takes a read-stream byte this cycle |
| rs_sel | output | 2 | Read-stream channel (0..2) |
| ws_valid | output | 1 | Write-stream byte offered |
| ws_data | output | 8 | Write-stream byte |
| ws_ready | input | 1 | Write-stream sink accepts the byte |
| ws_sel | output | 2 | Write-stream channel (0..2) |
| eof_valid | output | 1 | One-cycle end-of-frame strobe |
| eof_cmd | output | 4 | Command code of the finished frame |
| loc_addr | input | 6 | Local register read address |
| loc_data | output | 8 | Local register read data |

## Verification
Some properties are checked by assertions on every cycle:
- MISO only moves after a falling SCLK edge or a chip-select fall.
- The bit counter clears when a frame starts.
- Stream handshakes and the end-of-frame strobe are single-cycle pulses.
- The register pointer steps by one per data byte.
- Idle and illegal frames never produce a register write or stream traffic.

Only the bench scenarios can show the rest:
- Bytes actually land at the right addresses and wrap past 63.
- Read data comes back MSB first, one byte late.
- Dropped write bytes really vanish.
- Truncated frames leave registers and the strobe untouched.

// File: rtl/spi_dec_pkg.sv
package spi_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 6;
  localparam int SEL_W  = 2;
  localparam int CMD_W  = 4;

  localparam logic [BYTE_W-1:0] OP_RD_S0 = 8'h81;
  localparam logic [BYTE_W-1:0] OP_RD_S1 = 8'h83;
  localparam logic [BYTE_W-1:0] OP_RD_S2 = 8'h87;
  localparam logic [BYTE_W-1:0] OP_WR_S0 = 8'h91;
  localparam logic [BYTE_W-1:0] OP_WR_S1 = 8'h93;
  localparam logic [BYTE_W-1:0] OP_WR_S2 = 8'h97;
  localparam logic [BYTE_W-1:0] OP_IDLE  = 8'hFF;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE   = 4'd0,
    CMD_REG_WR = 4'd1,
    CMD_REG_RD = 4'd2,
    CMD_RD_S0  = 4'd3,
    CMD_RD_S1  = 4'd4,
    CMD_RD_S2  = 4'd5,
    CMD_WR_S0  = 4'd6,
    CMD_WR_S1  = 4'd7,
    CMD_WR_S2  = 4'd8,
    CMD_IDLE   = 4'd9,
    CMD_BAD    = 4'd10
  } cmd_e;

  function automatic logic is_rd_stream(cmd_e c);
    return (c == CMD_RD_S0) || (c == CMD_RD_S1) || (c == CMD_RD_S2);
  endfunction

  function automatic logic is_wr_stream(cmd_e c);
    return (c == CMD_WR_S0) || (c == CMD_WR_S1) || (c == CMD_WR_S2);
  endfunction

  function automatic logic [SEL_W-1:0] stream_sel(cmd_e c);
    case (c)
      CMD_RD_S1, CMD_WR_S1: return 2'd1;
      CMD_RD_S2, CMD_WR_S2: return 2'd2;
      default:              return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/spi_op_decode.sv
module spi_op_decode
  import spi_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output cmd_e              cmd,
  output logic [REG_AW-1:0] addr
);
  localparam int PFX_HI = BYTE_W - 1;

  always_comb begin
    addr = op[REG_AW-1:0];
    if (op[PFX_HI -: 2] == 2'b01) begin
      cmd = CMD_REG_WR;
    end else if (op[PFX_HI -: 2] == 2'b00) begin
      cmd = CMD_REG_RD;
    end else begin
      case (op)
        OP_RD_S0: cmd = CMD_RD_S0;
        OP_RD_S1: cmd = CMD_RD_S1;
        OP_RD_S2: cmd = CMD_RD_S2;
        OP_WR_S0: cmd = CMD_WR_S0;
        OP_WR_S1: cmd = CMD_WR_S1;
        OP_WR_S2: cmd = CMD_WR_S2;
        OP_IDLE:  cmd = CMD_IDLE;
        default:  cmd = CMD_BAD;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_array.sv
module spi_reg_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              frame_start,
  output logic              frame_end,
  output logic              byte_stb,
  output logic              byte_first,
  output logic [BYTE_W-1:0] byte_data,
  input  logic              load_req,
  input  logic [BYTE_W-1:0] load_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
  logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;
  logic rise, fall, cs_fall, cs_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr, tx_hold;
  logic first_q, load_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
      sclk_d    <= sclk_s;
      cs_d      <= cs_s;
    end
  end

  assign sclk_s  = sclk_sync[SYNC_STAGES-1];
  assign cs_s    = cs_sync[SYNC_STAGES-1];
  assign mosi_s  = mosi_sync[SYNC_STAGES-1];
  assign rise    = sclk_s & ~sclk_d & ~cs_s;
  assign fall    = ~sclk_s & sclk_d & ~cs_s;
  assign cs_fall = ~cs_s & cs_d;
  assign cs_rise = cs_s & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt     <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      tx_hold     <= '0;
      first_q     <= 1'b0;
      load_pend   <= 1'b0;
      byte_stb    <= 1'b0;
      byte_first  <= 1'b0;
      byte_data   <= '0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      byte_stb    <= 1'b0;
      frame_start <= cs_fall;
      frame_end   <= cs_rise;
      if (cs_fall) begin
        bit_cnt   <= '0;
        first_q   <= 1'b1;
        tx_sr     <= '0;
        load_pend <= 1'b0;
      end else begin
        if (rise) begin
          rx_sr <= {rx_sr[BYTE_W-3:0], mosi_s};
          if (bit_cnt == LAST_BIT) begin
            bit_cnt    <= '0;
            byte_stb   <= 1'b1;
            byte_data  <= {rx_sr, mosi_s};
            byte_first <= first_q;
            first_q    <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (fall) begin
          if (load_pend) begin
            tx_sr     <= tx_hold;
            load_pend <= 1'b0;
          end else begin
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
          end
        end
        if (load_req) begin
          tx_hold   <= load_data;
          load_pend <= 1'b1;
        end
      end
    end
  end

  assign miso = tx_sr[BYTE_W-1];

  assert_cnt_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (bit_cnt == '0));
  assert_miso_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !cs_fall) |=> $stable(miso));
  assert_stb_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);
endmodule

// File: rtl/spi_cmd_regdec.sv
module spi_cmd_regdec
  import spi_dec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              rs_valid,
  input  logic [BYTE_W-1:0] rs_data,
  output logic              rs_ready,
  output logic [SEL_W-1:0]  rs_sel,
  output logic              ws_valid,
  output logic [BYTE_W-1:0] ws_data,
  input  logic              ws_ready,
  output logic [SEL_W-1:0]  ws_sel,
  output logic              eof_valid,
  output logic [CMD_W-1:0]  eof_cmd,
  input  logic [REG_AW-1:0] loc_addr,
  output logic [BYTE_W-1:0] loc_data
);
  logic              frame_start, frame_end, byte_stb, byte_first;
  logic [BYTE_W-1:0] byte_data, load_data, arr_rdata;
  logic              load_req, reg_we;
  cmd_e              dec_cmd, cmd_q, act_cmd;
  logic [REG_AW-1:0] dec_addr, ptr, eff_ptr;

  spi_bit_engine #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) u_bits (
    .clk, .rst_n,
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso),
    .frame_start, .frame_end, .byte_stb, .byte_first, .byte_data,
    .load_req, .load_data
  );

  spi_op_decode u_dec (.op(byte_data), .cmd(dec_cmd), .addr(dec_addr));

  spi_reg_array #(.AW(REG_AW), .DW(BYTE_W)) u_regs (
    .clk, .rst_n,
    .we(reg_we), .waddr(ptr), .wdata(byte_data),
    .raddr_a(eff_ptr), .rdata_a(arr_rdata),
    .raddr_b(loc_addr), .rdata_b(loc_data)
  );

  assign act_cmd  = byte_first ? dec_cmd : cmd_q;
  assign eff_ptr  = byte_first ? dec_addr : ptr;
  assign rs_ready = byte_stb & is_rd_stream(act_cmd);
  assign rs_sel   = stream_sel(act_cmd);
  assign ws_valid = byte_stb & ~byte_first & is_wr_stream(cmd_q);
  assign ws_data  = byte_data;
  assign ws_sel   = stream_sel(cmd_q);
  assign reg_we   = byte_stb & ~byte_first & (cmd_q == CMD_REG_WR);
  assign load_req = byte_stb;

  always_comb begin
    if (act_cmd == CMD_REG_RD)       load_data = arr_rdata;
    else if (is_rd_stream(act_cmd))  load_data = rs_valid ? rs_data : '0;
    else                             load_data = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= CMD_NONE;
      ptr       <= '0;
      eof_valid <= 1'b0;
      eof_cmd   <= '0;
    end else begin
      eof_valid <= frame_end && (cmd_q != CMD_NONE);
      if (frame_end) eof_cmd <= cmd_q;
      if (frame_start) begin
        cmd_q <= CMD_NONE;
      end else if (byte_stb) begin
        if (byte_first) cmd_q <= dec_cmd;
        if (act_cmd == CMD_REG_RD)      ptr <= eff_ptr + 1'b1;
        else if (act_cmd == CMD_REG_WR) ptr <= byte_first ? dec_addr : ptr + 1'b1;
      end
    end
  end

  assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (ptr == REG_AW'($past(ptr) + 1'b1)));
  assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !byte_first && cmd_q == CMD_REG_RD && !frame_start)
      |=> (ptr == REG_AW'($past(ptr) + 1'b1)));
  assert_rs_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rs_ready |=> !rs_ready);
  assert_ws_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ws_valid |=> !ws_valid);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_IDLE && !(byte_stb && byte_first))
      |-> !(reg_we || ws_valid || rs_ready || (load_req && load_data != '0)));
  assert_bad_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_BAD && !(byte_stb && byte_first))
      |-> !(reg_we || ws_valid || rs_ready || (load_req && load_data != '0)));
  assert_eof_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eof_valid |=> !eof_valid);
endmodule

// File: tb/sim_spi_cmd_regdec.sv
module sim_spi_cmd_regdec;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic rs_valid = 1'b1;
  logic [7:0] rs_data;
  logic rs_ready;
  logic [1:0] rs_sel, ws_sel;
  logic ws_valid, ws_ready = 1'b1;
  logic [7:0] ws_data;
  logic eof_valid;
  logic [3:0] eof_cmd;
  logic [5:0] loc_addr = '0;
  logic [7:0] loc_data;

  int checks = 0, errors = 0, cyc = 0;
  int eof_seen = 0, ws_offer = 0, ws_got = 0, rs_idx = 0;
  logic [3:0] eof_last = '0;
  logic [1:0] ws_sel_last = '0, rs_sel_last = '0;
  logic [7:0] ws_log [16];
  logic [7:0] rs_src [4];
  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];
  logic [7:0] cmd_rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_regdec u0 (
    .clk, .rst_n, .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso,
    .rs_valid, .rs_data, .rs_ready, .rs_sel,
    .ws_valid, .ws_data, .ws_ready, .ws_sel,
    .eof_valid, .eof_cmd, .loc_addr, .loc_data
  );

  assign rs_data = rs_src[rs_idx % 4];

  always @(posedge clk) if (rs_ready) begin
    rs_idx <= rs_idx + 1;
    rs_sel_last <= rs_sel;
  end

  always @(negedge clk) begin
    if (eof_valid) begin eof_seen++; eof_last = eof_cmd; end
    if (ws_valid) begin
      ws_offer++;
      if (ws_ready) begin ws_log[ws_got % 16] = ws_data; ws_sel_last = ws_sel; ws_got++; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HP) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HP) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4*HP) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] cmd, input int n);
    logic [7:0] r;
    cs_low();
    spi_bits(cmd, 8, cmd_rx);
    for (int k = 0; k < n; k++) begin
      spi_bits(tx_buf[k], 8, r);
      rx_buf[k] = r;
    end
    cs_high();
  endtask

  function automatic logic [7:0] peek(input logic [5:0] a);
    return 8'h00;
  endfunction

  task automatic loc_rd(input logic [5:0] a, output logic [7:0] d);
    loc_addr = a;
    #1;
    d = loc_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 miso", spi_miso, 1'b0);
    chk("R10 eof_valid", eof_valid, 1'b0);
    chk("R10 ws_valid", ws_valid, 1'b0);
    chk("R10 rs_ready", rs_ready, 1'b0);
    for (int a = 0; a < 64; a += 21) begin
      loc_rd(6'(a), d);
      chk("R10 R11 reg reset", d, 8'h00);
    end
  endtask

  task automatic t_reg_write();
    logic [7:0] d;
    int e0 = eof_seen;
    tx_buf[0] = 8'hA1; tx_buf[1] = 8'hB2; tx_buf[2] = 8'hC3;
    run_frame(8'h45, 3);
    loc_rd(6'd5, d); chk("R2 R11 reg5", d, 8'hA1);
    loc_rd(6'd6, d); chk("R2 reg6", d, 8'hB2);
    loc_rd(6'd7, d); chk("R2 reg7", d, 8'hC3);
    loc_rd(6'd8, d); chk("R2 reg8 untouched", d, 8'h00);
    chk("R8 eof count wr", eof_seen, e0 + 1);
    chk("R8 eof code wr", eof_last, 4'd1);
  endtask

  task automatic t_wrap_write();
    logic [7:0] d;
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22;
    run_frame(8'h7F, 2);
    loc_rd(6'd63, d); chk("R2 reg63", d, 8'h11);
    loc_rd(6'd0, d);  chk("R2 wrap reg0", d, 8'h22);
  endtask

  task automatic t_reg_read();
    for (int k = 0; k < 3; k++) tx_buf[k] = 8'h5A;
    run_frame(8'h05, 3);
    chk("R1 miso zero in cmd byte", cmd_rx, 8'h00);
    chk("R3 rd reg5", rx_buf[0], 8'hA1);
    chk("R3 rd reg6", rx_buf[1], 8'hB2);
    chk("R3 rd reg7", rx_buf[2], 8'hC3);
    chk("R8 eof code rd", eof_last, 4'd2);
    run_frame(8'h3F, 2);
    chk("R1 cmd byte after read", cmd_rx, 8'h00);
    chk("R3 rd reg63", rx_buf[0], 8'h11);
    chk("R3 rd wrap reg0", rx_buf[1], 8'h22);
  endtask

  task automatic t_stream_read();
    int i0;
    rs_src[0] = 8'hDE; rs_src[1] = 8'hAD; rs_src[2] = 8'hBE; rs_src[3] = 8'hEF;
    rs_valid = 1'b1;
    for (int k = 0; k < 3; k++) tx_buf[k] = 8'h00;
    i0 = rs_idx;
    run_frame(8'h83, 3);
    for (int k = 0; k < 3; k++) chk("R4 stream byte", rx_buf[k], rs_src[(i0 + k) % 4]);
    chk("R4 pulls per byte", rs_idx - i0, 4);
    chk("R4 sel 1", rs_sel_last, 2'd1);
    chk("R8 eof code rs1", eof_last, 4'd4);
    rs_valid = 1'b0;
    run_frame(8'h87, 2);
    chk("R4 empty byte0", rx_buf[0], 8'h00);
    chk("R4 empty byte1", rx_buf[1], 8'h00);
    chk("R4 sel 2", rs_sel_last, 2'd2);
    rs_valid = 1'b1;
  endtask

  task automatic t_stream_write();
    int g0 = ws_got, o0;
    ws_ready = 1'b1;
    tx_buf[0] = 8'h5A; tx_buf[1] = 8'h3C;
    run_frame(8'h97, 2);
    chk("R5 got two", ws_got - g0, 2);
    chk("R5 byte0", ws_log[g0 % 16], 8'h5A);
    chk("R5 byte1", ws_log[(g0 + 1) % 16], 8'h3C);
    chk("R5 sel 2", ws_sel_last, 2'd2);
    chk("R8 eof code ws2", eof_last, 4'd8);
    ws_ready = 1'b0;
    o0 = ws_offer; g0 = ws_got;
    tx_buf[0] = 8'h77;
    run_frame(8'h91, 1);
    chk("R5 offered under backpressure", ws_offer - o0, 1);
    chk("R5 dropped", ws_got - g0, 0);
    ws_ready = 1'b1;
    run_frame(8'h93, 0);
    chk("R5 no retry", ws_got - g0, 0);
    chk("R8 eof code ws1", eof_last, 4'd7);
  endtask

  task automatic t_idle();
    logic [7:0] d;
    int o0 = ws_offer, i0 = rs_idx;
    tx_buf[0] = 8'h12; tx_buf[1] = 8'h34;
    run_frame(8'hFF, 2);
    chk("R6 miso 0 b0", rx_buf[0], 8'h00);
    chk("R6 miso 0 b1", rx_buf[1], 8'h00);
    loc_rd(6'd63, d); chk("R6 reg63 kept", d, 8'h11);
    loc_rd(6'd5, d);  chk("R6 reg5 kept", d, 8'hA1);
    chk("R6 no stream", (ws_offer - o0) + (rs_idx - i0), 0);
    chk("R8 eof code idle", eof_last, 4'd9);
  endtask

  task automatic t_bad();
    logic [7:0] d;
    int o0 = ws_offer, i0 = rs_idx;
    tx_buf[0] = 8'h99; tx_buf[1] = 8'h88;
    run_frame(8'hC5, 2);
    chk("R7 miso 0", rx_buf[0] | rx_buf[1], 8'h00);
    chk("R8 eof code bad", eof_last, 4'd10);
    run_frame(8'h85, 2);
    chk("R7 miso 0 85", rx_buf[0] | rx_buf[1], 8'h00);
    loc_rd(6'd5, d); chk("R7 reg5 kept", d, 8'hA1);
    chk("R7 no stream", (ws_offer - o0) + (rs_idx - i0), 0);
  endtask

  task automatic t_partial();
    logic [7:0] d, r;
    int e0;
    cs_low();
    spi_bits(8'h45, 8, r);
    spi_bits(8'hF0, 4, r);
    cs_high();
    loc_rd(6'd5, d); chk("R9 partial byte dropped", d, 8'hA1);
    e0 = eof_seen;
    cs_low();
    spi_bits(8'h45, 5, r);
    cs_high();
    chk("R8 no eof short frame", eof_seen, e0);
    tx_buf[0] = 8'h00;
    run_frame(8'h05, 1);
    chk("R1 counter reset after short frame", rx_buf[0], 8'hA1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reg_write();
    t_wrap_write();
    t_reg_read();
    t_stream_read();
    t_stream_write();
    t_idle();
    t_bad();
    t_partial();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule